// File: doc/BRIEF.md
# DMA Dispatcher Status and Stop Control

This block is the status and halt logic that sits beside a scatter-gather DMA dispatcher. It watches the fill levels of the read command queue, the write command queue and the response queue. It also watches the activity flags of the two data movers and the error and end-of-packet indications from the write mover. From these it builds a 32-bit status word, which software reads through a small register port with one cycle of read latency.

Software can ask the engine to halt. A manual halt takes effect only once both movers have drained the work already in progress. The engine can also be set to halt on its own when the write mover sees an error beat, or when a packet closes before its programmed length. Every halt raises a sticky interrupt flag. A software reset runs a timed reset phase. That phase lasts a minimum number of cycles and continues until both movers are idle. While it runs, new descriptor pushes are refused and the sticky state is wiped.

The register port has three addresses. Address 0 holds the status word: reading it returns the word, and writing 1 to bit 7, 8 or 9 clears that sticky bit. Address 1 holds the control word. Writing bit 0 requests a halt and writing bit 1 resumes. Bit 2 is the halt-on-error enable and bit 3 is the halt-on-short-packet enable; these two are stored and read back. Address 2 starts the reset phase when written with bit 0 set.

Top module: `dsp_status_ctl`

## Requirements
- R1: Status word layout: bit 0 busy, bit 1 both command queues empty, bit 2 any command queue full, bit 3 response queue empty, bit 4 response queue full, bit 5 halted, bit 6 reset phase active, bit 7 halted by error, bit 8 halted by short packet, bit 9 interrupt; bits 31:10 always read 0.
- R2: Bit 1 is 1 only when the read and the write command queue levels are both zero.
- R3: Bit 2 is 1 when either command queue level equals its depth. Bits 3 and 4 report the response queue at level zero and at full depth.
- R4: Bit 0 is 1 whenever any command queue level is non-zero or either mover is active. Response queue contents alone do not make the block busy.
- R5: A write of 1 to control bit 0 drops `dispatch_en_o` on the next cycle. Bit 5 rises only on the cycle after both movers are seen idle, so never in the cycle of the request.
- R6: With control bit 2 set, an error beat sets bits 7 and 5 on the next cycle. With control bit 2 clear, an error beat changes nothing.
- R7: With control bit 3 set, an end-of-packet in packet mode with a non-zero remaining byte count sets bits 8 and 5. An end-of-packet with zero bytes remaining, or one outside packet mode, changes nothing.
- R8: Writing 1 to address 2 bit 0 raises bit 6 on the next cycle. Bit 6 stays high for at least RST_MIN_CYC cycles, and longer while either mover is active. With idle movers it stays high exactly RST_MIN_CYC cycles.
- R9: While bit 6 is high, `desc_push_ok_o` is 0 whatever `desc_push_i` is; otherwise it follows `desc_push_i`.
- R10: Bits 7, 8 and 9 are sticky. Writing 1 to a bit's position at address 0 clears it, writing 0 leaves it set, and the reset phase clears all three as well as bit 5.
- R11: Bit 9 and `irq_o` set on every halt, whether manual, by error or by short packet, and stay set until cleared.
- R12: A write of 1 to control bit 1 clears bit 5 and re-enables dispatch; the stored enables and bit 9 are unchanged.
- R13: A read returns data one cycle after `reg_rd_i`, and `reg_rdata_o` holds when no read is issued. Address 1 reads back bits 2 and 3 with bits 0 and 1 as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rd_cmd_lvl_i | input | RD_LW | Read command queue fill level |
| wr_cmd_lvl_i | input | WR_LW | Write command queue fill level |
| rsp_lvl_i | input | RSP_LW | Response queue fill level |
| rd_busy_i | input | 1 | Read mover has an operation in progress |
| wr_busy_i | input | 1 | Write mover has an operation in progress |
| wr_err_beat_i | input | 1 | Error beat entered the write mover (one cycle) |
| wr_eop_i | input | 1 | End of packet seen by the write mover (one cycle) |
| wr_pkt_mode_i | input | 1 | Current write transfer is packet based |
| wr_bytes_left_i | input | LEN_W | Bytes still due for the current descriptor when end of packet arrives |
| desc_push_i | input | 1 | Descriptor push request from the front end |
| desc_push_ok_o | output | 1 | Push accepted (blocked during the reset phase) |
| dispatch_en_o | output | 1 | Dispatcher may issue new commands |
| irq_o | output | 1 | Interrupt flag (status bit 9) |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, valid one cycle after the strobe |

## Verification
The bound checker watches several relations every cycle. The upper status bits stay zero. The empty and busy flags follow the queue levels and mover flags. A halt can begin only after an error, a short packet or an idle cycle. An enabled error or short packet always produces its sticky bit and the halt bit. The reset phase never ends early or while a mover is active, and pushes are always refused during it. The bench scenarios cover the remaining behaviour. They show the exact cycle a manual halt lands relative to the request. They show that disabled or non-qualifying events leave the status unchanged, and that writing 1 clears a sticky bit while writing 0 does not. They show the exact length of a reset phase with idle movers, resume preserving the interrupt, and read data holding between reads.

// File: rtl/dsp_sts_pkg.sv
package dsp_sts_pkg;

  localparam logic [1:0] ADDR_STATUS = 2'd0;
  localparam logic [1:0] ADDR_CTRL   = 2'd1;
  localparam logic [1:0] ADDR_SWRST  = 2'd2;

  // status word bit positions (software decodes these)
  localparam int ST_BUSY      = 0;
  localparam int ST_DESC_EMP  = 1;
  localparam int ST_DESC_FULL = 2;
  localparam int ST_RSP_EMP   = 3;
  localparam int ST_RSP_FULL  = 4;
  localparam int ST_HALTED    = 5;
  localparam int ST_RESETTING = 6;
  localparam int ST_ERR_HALT  = 7;
  localparam int ST_EARLY_HLT = 8;
  localparam int ST_IRQ       = 9;
  localparam int ST_USED      = 10;

  // control word bit positions
  localparam int CT_HALT_REQ  = 0;
  localparam int CT_RESUME    = 1;
  localparam int CT_ERR_EN    = 2;
  localparam int CT_EARLY_EN  = 3;

  typedef struct packed {
    logic irq;
    logic early;
    logic err;
  } sticky_t;

endpackage

// File: rtl/dsp_lvl_flags.sv
module dsp_lvl_flags #(
  parameter int DEPTH = 8,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic [LW-1:0] lvl_i,
  output logic          empty_o,
  output logic          full_o
);

  localparam logic [LW-1:0] FULL_LVL = LW'(DEPTH);

  always_comb begin
    empty_o = (lvl_i == '0);
    full_o  = (lvl_i >= FULL_LVL);
  end

endmodule

// File: rtl/dsp_reset_seq.sv
module dsp_reset_seq #(
  parameter int RST_MIN_CYC = 4,
  localparam int CW = $clog2(RST_MIN_CYC + 1)
) (
  input  logic clk_i,
  input  logic rst_n,
  input  logic start_i,
  input  logic movers_idle_i,
  output logic resetting_o
);

  localparam logic [CW-1:0] LAST = CW'(RST_MIN_CYC - 1);

  logic          act_q, act_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          seq_en;

  always_comb begin
    act_n = act_q;
    cnt_n = cnt_q;
    if (start_i) begin
      act_n = 1'b1;
      cnt_n = '0;
    end else if (act_q) begin
      if ((cnt_q >= LAST) && movers_idle_i) begin
        act_n = 1'b0;
      end else if (cnt_q < LAST) begin
        cnt_n = cnt_q + 1'b1;
      end
    end
    seq_en = start_i | act_q;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      cnt_q <= '0;
    end else if (seq_en) begin
      act_q <= act_n;
      cnt_q <= cnt_n;
    end
  end

  assign resetting_o = act_q;

endmodule

// File: rtl/dsp_stop_ctl.sv
module dsp_stop_ctl
  import dsp_sts_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_n,
  input  logic    clr_i,
  input  logic    halt_req_i,
  input  logic    resume_i,
  input  logic    err_en_i,
  input  logic    early_en_i,
  input  logic    err_beat_i,
  input  logic    early_evt_i,
  input  logic    movers_idle_i,
  input  sticky_t w1c_i,
  output logic    halted_o,
  output logic    pending_o,
  output sticky_t sticky_o
);

  logic    halted_q, halted_n;
  logic    pend_q, pend_n;
  sticky_t stk_q, stk_n;
  logic    err_hit, early_hit, drain_done, set_halt, upd_en;

  always_comb begin
    err_hit    = err_en_i & err_beat_i & ~clr_i;
    early_hit  = early_en_i & early_evt_i & ~clr_i;
    drain_done = pend_q & movers_idle_i & ~resume_i & ~clr_i;
    set_halt   = drain_done | err_hit | early_hit;

    pend_n = pend_q;
    if (clr_i || resume_i || drain_done) begin
      pend_n = 1'b0;
    end else if (halt_req_i && !halted_q) begin
      pend_n = 1'b1;
    end

    halted_n = halted_q;
    if (clr_i || resume_i) halted_n = 1'b0;
    if (set_halt)          halted_n = 1'b1;

    if (clr_i) begin
      stk_n = '0;
    end else begin
      stk_n.err   = err_hit   | (stk_q.err   & ~w1c_i.err);
      stk_n.early = early_hit | (stk_q.early & ~w1c_i.early);
      stk_n.irq   = set_halt  | (stk_q.irq   & ~w1c_i.irq);
    end

    upd_en = clr_i | resume_i | halt_req_i | set_halt | (|w1c_i);
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      halted_q <= 1'b0;
      pend_q   <= 1'b0;
      stk_q    <= '0;
    end else if (upd_en) begin
      halted_q <= halted_n;
      pend_q   <= pend_n;
      stk_q    <= stk_n;
    end
  end

  assign halted_o  = halted_q;
  assign pending_o = pend_q;
  assign sticky_o  = stk_q;

endmodule

// File: rtl/dsp_status_ctl.sv
module dsp_status_ctl
  import dsp_sts_pkg::*;
#(
  parameter int RD_DEPTH    = 8,
  parameter int WR_DEPTH    = 8,
  parameter int RSP_DEPTH   = 8,
  parameter int LEN_W       = 32,
  parameter int RST_MIN_CYC = 4,
  localparam int RD_LW  = $clog2(RD_DEPTH + 1),
  localparam int WR_LW  = $clog2(WR_DEPTH + 1),
  localparam int RSP_LW = $clog2(RSP_DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [RD_LW-1:0]  rd_cmd_lvl_i,
  input  logic [WR_LW-1:0]  wr_cmd_lvl_i,
  input  logic [RSP_LW-1:0] rsp_lvl_i,
  input  logic              rd_busy_i,
  input  logic              wr_busy_i,
  input  logic              wr_err_beat_i,
  input  logic              wr_eop_i,
  input  logic              wr_pkt_mode_i,
  input  logic [LEN_W-1:0]  wr_bytes_left_i,
  input  logic              desc_push_i,
  output logic              desc_push_ok_o,
  output logic              dispatch_en_o,
  output logic              irq_o,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [1:0]        reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o
);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rsync_q;
  logic       rst_n_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rsync_q <= 2'b00;
    else         rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_n_s = rsync_q[1];

  // queue flags
  logic rd_emp, rd_full, wr_emp, wr_full, rsp_emp, rsp_full;

  dsp_lvl_flags #(.DEPTH(RD_DEPTH)) u_rd_flags (
    .lvl_i(rd_cmd_lvl_i), .empty_o(rd_emp), .full_o(rd_full));
  dsp_lvl_flags #(.DEPTH(WR_DEPTH)) u_wr_flags (
    .lvl_i(wr_cmd_lvl_i), .empty_o(wr_emp), .full_o(wr_full));
  dsp_lvl_flags #(.DEPTH(RSP_DEPTH)) u_rsp_flags (
    .lvl_i(rsp_lvl_i), .empty_o(rsp_emp), .full_o(rsp_full));

  // register decode
  logic    wr_sts, wr_ctl, sw_rst_req, halt_req, resume;
  logic    early_evt, movers_idle;
  sticky_t w1c;

  always_comb begin
    wr_sts     = reg_wr_i & (reg_addr_i == ADDR_STATUS);
    wr_ctl     = reg_wr_i & (reg_addr_i == ADDR_CTRL);
    sw_rst_req = reg_wr_i & (reg_addr_i == ADDR_SWRST) & reg_wdata_i[0];
    halt_req   = wr_ctl & reg_wdata_i[CT_HALT_REQ];
    resume     = wr_ctl & reg_wdata_i[CT_RESUME];
    w1c.irq    = wr_sts & reg_wdata_i[ST_IRQ];
    w1c.early  = wr_sts & reg_wdata_i[ST_EARLY_HLT];
    w1c.err    = wr_sts & reg_wdata_i[ST_ERR_HALT];
    early_evt  = wr_eop_i & wr_pkt_mode_i & (wr_bytes_left_i != '0);
    movers_idle = ~rd_busy_i & ~wr_busy_i;
  end

  // stored enables
  logic err_en_q, early_en_q;

  always_ff @(posedge clk_i or negedge rst_n_s) begin
    if (!rst_n_s) begin
      err_en_q   <= 1'b0;
      early_en_q <= 1'b0;
    end else if (wr_ctl) begin
      err_en_q   <= reg_wdata_i[CT_ERR_EN];
      early_en_q <= reg_wdata_i[CT_EARLY_EN];
    end
  end

  // reset phase
  logic resetting;

  dsp_reset_seq #(.RST_MIN_CYC(RST_MIN_CYC)) u_rst_seq (
    .clk_i         (clk_i),
    .rst_n         (rst_n_s),
    .start_i       (sw_rst_req),
    .movers_idle_i (movers_idle),
    .resetting_o   (resetting)
  );

  // halt control
  logic    halted, halt_pend;
  sticky_t stk;

  dsp_stop_ctl u_stop (
    .clk_i         (clk_i),
    .rst_n         (rst_n_s),
    .clr_i         (sw_rst_req | resetting),
    .halt_req_i    (halt_req),
    .resume_i      (resume),
    .err_en_i      (err_en_q),
    .early_en_i    (early_en_q),
    .err_beat_i    (wr_err_beat_i),
    .early_evt_i   (early_evt),
    .movers_idle_i (movers_idle),
    .w1c_i         (w1c),
    .halted_o      (halted),
    .pending_o     (halt_pend),
    .sticky_o      (stk)
  );

  // status word
  logic [31:0] sts_w;
  logic [31:0] ctl_w;

  always_comb begin
    sts_w               = '0;
    sts_w[ST_BUSY]      = ~rd_emp | ~wr_emp | ~movers_idle;
    sts_w[ST_DESC_EMP]  = rd_emp & wr_emp;
    sts_w[ST_DESC_FULL] = rd_full | wr_full;
    sts_w[ST_RSP_EMP]   = rsp_emp;
    sts_w[ST_RSP_FULL]  = rsp_full;
    sts_w[ST_HALTED]    = halted;
    sts_w[ST_RESETTING] = resetting;
    sts_w[ST_ERR_HALT]  = stk.err;
    sts_w[ST_EARLY_HLT] = stk.early;
    sts_w[ST_IRQ]       = stk.irq;

    ctl_w               = '0;
    ctl_w[CT_ERR_EN]    = err_en_q;
    ctl_w[CT_EARLY_EN]  = early_en_q;
  end

  // read port, one cycle latency
  logic [31:0] rdata_q, rdata_n;

  always_comb begin
    unique case (reg_addr_i)
      ADDR_STATUS: rdata_n = sts_w;
      ADDR_CTRL:   rdata_n = ctl_w;
      default:     rdata_n = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_n_s) begin
    if (!rst_n_s)      rdata_q <= '0;
    else if (reg_rd_i) rdata_q <= rdata_n;
  end

  assign reg_rdata_o    = rdata_q;
  assign desc_push_ok_o = desc_push_i & ~resetting;
  assign dispatch_en_o  = ~halted & ~halt_pend & ~resetting;
  assign irq_o          = stk.irq;

endmodule

// File: rtl/dsp_status_chk.sv
module dsp_status_chk #(
  parameter int RD_LW       = 4,
  parameter int WR_LW       = 4,
  parameter int RST_MIN_CYC = 4,
  localparam int CW = $clog2(RST_MIN_CYC + 2)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [31:0]      sts,
  input logic [RD_LW-1:0] rd_lvl,
  input logic [WR_LW-1:0] wr_lvl,
  input logic             rd_act,
  input logic             wr_act,
  input logic             err_beat,
  input logic             err_en,
  input logic             early_evt,
  input logic             early_en,
  input logic             sw_rst,
  input logic             resetting,
  input logic             push_ok
);

  localparam logic [CW-1:0] SAT = CW'(RST_MIN_CYC + 1);

  logic [CW-1:0] hi_cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         hi_cnt_q <= '0;
    else if (!resetting) hi_cnt_q <= '0;
    else if (hi_cnt_q < SAT) hi_cnt_q <= hi_cnt_q + 1'b1;
  end

  p_upper_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    sts[31:10] == '0);

  p_desc_empty_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sts[1] == ((rd_lvl == '0) && (wr_lvl == '0)));

  p_busy_active_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_act || wr_act) |-> sts[0]);

  p_halt_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts[5]) |-> ($past(err_en && err_beat) || $past(early_en && early_evt)
                      || $past(!rd_act && !wr_act)));

  p_err_halt_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (err_en && err_beat && !resetting && !sw_rst) |=> (sts[7] && sts[5] && sts[9]));

  p_early_halt_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (early_en && early_evt && !resetting && !sw_rst) |=> (sts[8] && sts[5] && sts[9]));

  p_rst_min_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(resetting) |-> (hi_cnt_q >= CW'(RST_MIN_CYC)));

  p_rst_exit_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(resetting) |-> $past(!rd_act && !wr_act));

  p_push_blocked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    resetting |-> !push_ok);

  p_rst_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    resetting |=> (sts[9:7] == 3'b000) && !sts[5]);

endmodule

bind dsp_status_ctl dsp_status_chk #(
  .RD_LW(RD_LW), .WR_LW(WR_LW), .RST_MIN_CYC(RST_MIN_CYC)
) u_status_chk (
  .clk       (clk_i),
  .rst_n     (rst_n_s),
  .sts       (sts_w),
  .rd_lvl    (rd_cmd_lvl_i),
  .wr_lvl    (wr_cmd_lvl_i),
  .rd_act    (rd_busy_i),
  .wr_act    (wr_busy_i),
  .err_beat  (wr_err_beat_i),
  .err_en    (err_en_q),
  .early_evt (early_evt),
  .early_en  (early_en_q),
  .sw_rst    (sw_rst_req),
  .resetting (resetting),
  .push_ok   (desc_push_ok_o)
);

// File: tb/dsp_status_ctl_tb.sv
`timescale 1ns/1ps
module dsp_status_ctl_tb_top;

  localparam int RST_MIN = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  rd_lvl, wr_lvl, rsp_lvl;
  logic        rd_busy, wr_busy, err_beat, eop, pkt_mode;
  logic [31:0] bytes_left;
  logic        push, push_ok, disp_en, irq;
  logic        reg_wr, reg_rd;
  logic [1:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dsp_status_ctl #(.RST_MIN_CYC(RST_MIN)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .rd_cmd_lvl_i(rd_lvl), .wr_cmd_lvl_i(wr_lvl), .rsp_lvl_i(rsp_lvl),
    .rd_busy_i(rd_busy), .wr_busy_i(wr_busy),
    .wr_err_beat_i(err_beat), .wr_eop_i(eop), .wr_pkt_mode_i(pkt_mode),
    .wr_bytes_left_i(bytes_left),
    .desc_push_i(push), .desc_push_ok_o(push_ok),
    .dispatch_en_o(disp_en), .irq_o(irq),
    .reg_wr_i(reg_wr), .reg_rd_i(reg_rd), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata)
  );

  // {rd_lvl, wr_lvl, rsp_lvl, rd_busy, wr_busy, expected status[4:0]}
  localparam logic [18:0] VEC [0:9] = '{
    {4'd0, 4'd0, 4'd0, 1'b0, 1'b0, 5'b01010},
    {4'd1, 4'd0, 4'd0, 1'b0, 1'b0, 5'b01001},
    {4'd0, 4'd3, 4'd0, 1'b0, 1'b0, 5'b01001},
    {4'd8, 4'd0, 4'd0, 1'b0, 1'b0, 5'b01101},
    {4'd0, 4'd8, 4'd0, 1'b0, 1'b0, 5'b01101},
    {4'd0, 4'd0, 4'd8, 1'b0, 1'b0, 5'b10010},
    {4'd0, 4'd0, 4'd0, 1'b1, 1'b0, 5'b01011},
    {4'd0, 4'd0, 4'd0, 1'b0, 1'b1, 5'b01011},
    {4'd8, 4'd8, 4'd4, 1'b1, 1'b1, 5'b00101},
    {4'd7, 4'd7, 4'd7, 1'b0, 1'b0, 5'b00001}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
    reg_rd = 1'b1; reg_addr = a;
    @(posedge clk); #1;
    d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic pulse_err();
    err_beat = 1'b1; @(negedge clk); err_beat = 1'b0;
  endtask

  task automatic pulse_eop(input logic pm, input logic [31:0] left);
    eop = 1'b1; pkt_mode = pm; bytes_left = left;
    @(negedge clk);
    eop = 1'b0; pkt_mode = 1'b0; bytes_left = '0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog (all requirements) actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    rst_n = 1'b0;
    rd_lvl = '0; wr_lvl = '0; rsp_lvl = '0;
    rd_busy = 0; wr_busy = 0; err_beat = 0; eop = 0; pkt_mode = 0; bytes_left = '0;
    push = 1'b1; reg_wr = 0; reg_rd = 0; reg_addr = '0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // reset state
    reg_read(2'd0, d); chk("R1 reset status", d, 32'h0000_000A);
    reg_read(2'd1, d); chk("R13 reset control", d, 32'h0);
    chk("R11 reset irq", {31'b0, irq}, 32'h0);
    chk("R5 reset dispatch_en", {31'b0, disp_en}, 32'h1);
    chk("R9 reset push_ok", {31'b0, push_ok}, 32'h1);

    // flag vectors: R2 R3 R4 (and R1 upper bits)
    for (int i = 0; i < 10; i++) begin
      {rd_lvl, wr_lvl, rsp_lvl, rd_busy, wr_busy} = VEC[i][18:5];
      reg_read(2'd0, d);
      chk($sformatf("R2/R3/R4 vector %0d", i), d, {27'b0, VEC[i][4:0]});
    end
    rd_lvl = '0; wr_lvl = '0; rsp_lvl = '0; rd_busy = 0; wr_busy = 0;
    @(negedge clk);

    // R5 manual halt waits for movers to drain
    wr_busy = 1'b1;
    reg_write(2'd1, 32'h1);
    chk("R5 dispatch_en drops after request", {31'b0, disp_en}, 32'h0);
    repeat (3) @(negedge clk);
    reg_read(2'd0, d); chk("R5 no halt while mover active", d, 32'h0000_000B);
    wr_busy = 1'b0;
    @(negedge clk);
    reg_read(2'd0, d); chk("R5 R11 halt after drain", d, 32'h0000_022A);
    chk("R11 irq pin", {31'b0, irq}, 32'h1);

    // R12 resume keeps irq
    reg_write(2'd1, 32'h2);
    reg_read(2'd0, d); chk("R12 resume clears halt", d, 32'h0000_020A);
    chk("R12 dispatch_en back", {31'b0, disp_en}, 32'h1);
    reg_write(2'd0, 32'h200);
    reg_read(2'd0, d); chk("R10 irq write-one clear", d, 32'h0000_000A);

    // R5 halt never in the request cycle, even idle
    reg_write(2'd1, 32'h1);
    reg_read(2'd0, d); chk("R5 not halted first cycle", d, 32'h0000_000A);
    reg_read(2'd0, d); chk("R5 halted second cycle", d, 32'h0000_022A);
    reg_write(2'd1, 32'h2);
    reg_write(2'd0, 32'h200);

    // R6 error halt, disabled and enabled
    reg_write(2'd1, 32'h0);
    pulse_err();
    reg_read(2'd0, d); chk("R6 error ignored when disabled", d, 32'h0000_000A);
    reg_write(2'd1, 32'h4);
    pulse_err();
    reg_read(2'd0, d); chk("R6 error halt", d, 32'h0000_02AA);
    chk("R6 dispatch_en low", {31'b0, disp_en}, 32'h0);
    reg_write(2'd0, 32'h0);
    reg_read(2'd0, d); chk("R10 write zero keeps sticky", d, 32'h0000_02AA);
    reg_write(2'd1, 32'h6);
    reg_write(2'd0, 32'h280);
    reg_read(2'd0, d); chk("R10 clear err and irq", d, 32'h0000_000A);

    // R7 short packet
    reg_write(2'd1, 32'h8);
    pulse_eop(1'b1, 32'd0);
    reg_read(2'd0, d); chk("R7 full-length packet ignored", d, 32'h0000_000A);
    pulse_eop(1'b0, 32'd5);
    reg_read(2'd0, d); chk("R7 non-packet eop ignored", d, 32'h0000_000A);
    pulse_eop(1'b1, 32'd5);
    reg_read(2'd0, d); chk("R7 early end halts", d, 32'h0000_032A);
    reg_write(2'd1, 32'hA);
    reg_write(2'd0, 32'h100);
    reg_read(2'd0, d); chk("R10 clear early, irq stays", d, 32'h0000_020A);
    reg_write(2'd0, 32'h200);

    // R13 latency and hold, control readback
    reg_write(2'd1, 32'hC);
    reg_read(2'd1, d); chk("R13 control readback", d, 32'h0000_000C);
    reg_write(2'd1, 32'h4);
    @(negedge clk);
    chk("R13 rdata holds without read", reg_rdata, 32'h0000_000C);
    reg_read(2'd2, d); chk("R13 reset address reads zero", d, 32'h0);

    // R8 R9 R10 reset phase with active mover and sticky state
    pulse_err();
    reg_read(2'd0, d); chk("R6 error halt before reset", d, 32'h0000_02AA);
    wr_busy = 1'b1;
    reg_write(2'd2, 32'h1);
    reg_read(2'd0, d); chk("R8 R10 resetting, sticky cleared", d, 32'h0000_004B);
    chk("R9 push refused", {31'b0, push_ok}, 32'h0);
    repeat (8) @(negedge clk);
    chk("R8 held while mover active", {31'b0, push_ok}, 32'h0);
    wr_busy = 1'b0;
    @(negedge clk);
    chk("R8 R9 ends after idle", {31'b0, push_ok}, 32'h1);
    reg_read(2'd0, d); chk("R8 status after reset", d, 32'h0000_000A);

    // R8 exact length with idle movers
    begin
      int n = 0;
      reg_write(2'd2, 32'h1);
      while (!push_ok && n < 20) begin
        n++;
        @(negedge clk);
      end
      chk("R8 reset phase length", n, RST_MIN);
    end
    push = 1'b0;
    @(negedge clk);
    chk("R9 push_ok follows push", {31'b0, push_ok}, 32'h0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule